// File: doc/BRIEF.md
# Variable-Latency Execute Stage

This block is the execute step of a small in-order integer pipeline. It takes one decoded instruction at a time from an upstream latch over a valid/ready link. Supported operations are add, subtract, add-immediate, multiply, load/store address generation and branch-if-equal. Each operation occupies the stage for a fixed number of cycles set by parameters: one count for multiply and one for everything else. A down-counter measures that time. The result, the program counter and the raw instruction word then go into a downstream latch that has its own valid bit.

The upstream latch is not released when the operation starts. It is released only in the cycle the downstream latch is loaded. As a result, a full downstream latch holds the finished result inside the stage and stalls the producer. For a branch, the stage compares the two operands by subtraction and computes the redirect address. It emits a one-cycle resolve pulse that lets the decode side drop its branch-pending state.

Back-pressure rules:
- The upstream side must hold `in_valid` and all `in_*` fields steady until it sees `in_ready`.
- The stage loads its output latch only while that latch is empty. The latch then holds its fields steady until the cycle `out_ready` is high.

Top module: `exu_stage`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, in_ready and br_done are 0 and busy_cycles is 0.
- R2: An operation other than multiply, presented to an idle stage, occupies the stage for ALU_LAT cycles. With the output latch empty, in_ready is high in cycle ALU_LAT, counting the first cycle in_valid is seen as cycle 1, and out_valid rises at the following clock edge.
- R3: Multiply (op code 3) occupies the stage for MUL_LAT cycles with the same timing as R2, and its result is the low 32 bits of a times b.
- R4: Op codes: 0 add gives a+b, 1 sub gives a-b, 2 addi gives a plus the sign-extended 16-bit imm, and 7 (reserved) gives 0 with ALU_LAT timing.
- R5: Load (op 4) and store (op 5) give the address a plus the sign-extended imm.
- R6: Branch (op 6) is taken when a-b is zero. Its out_result and br_target are then pc+4+(sign-extended imm shifted left by 2); otherwise both are pc+4. br_taken shows the decision.
- R7: br_done is a one-cycle pulse that coincides with the first cycle of out_valid, and it occurs only for the branch op.
- R8: A finished result is written to the output latch only in a cycle where out_valid is low. A cycle where out_valid and out_ready are both high does not load it; the load follows one cycle later.
- R9: in_ready is high only in the cycle the output latch is loaded. A second instruction is not started while one is in the stage, so in_ready stays low while a finished result waits.
- R10: While out_valid is high and out_ready is low, out_valid and all out_* fields hold. A cycle with out_ready high clears out_valid.
- R11: busy_cycles rises by exactly one for each cycle of countdown, and not at all while a finished result waits or the stage is idle.
- R12: out_pc and out_tag carry the pc and tag of the instruction that produced out_result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream latch holds an instruction |
| in_ready | output | 1 | Upstream latch is freed at this edge |
| in_op | input | 3 | Operation code |
| in_a | input | DW | First source operand |
| in_b | input | DW | Second source operand |
| in_imm | input | 16 | Immediate / branch offset |
| in_pc | input | DW | Address of the instruction |
| in_tag | input | DW | Raw instruction word, passed through |
| out_valid | output | 1 | Output latch is full |
| out_ready | input | 1 | Downstream consumes the latch at this edge |
| out_op | output | 3 | Operation code of the held result |
| out_result | output | DW | Result, address or redirect PC |
| out_pc | output | DW | PC of the held instruction |
| out_tag | output | DW | Instruction word of the held instruction |
| br_done | output | 1 | Branch resolved; clears branch-pending upstream |
| br_taken | output | 1 | Branch decision, valid with br_done |
| br_target | output | DW | Redirect PC, valid with br_done |
| busy_cycles | output | BUSY_W | Count of countdown cycles |

## Verification
Two things can fall in the same cycle: the countdown of a new instruction reaching its end, and the downstream side draining the previously held result. The bench fills the output latch and holds out_ready low. It then runs a multiply to completion so that the result waits. After that it raises out_ready for one cycle. In that cycle in_ready must stay low, the latch must empty at the edge, and the waiting result must load one edge later with its own pc and tag. busy_cycles must have grown by exactly MUL_LAT across the whole wait.

// File: rtl/exu_pkg.sv
package exu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDI = 3'd2,
    OP_MUL  = 3'd3,
    OP_LW   = 3'd4,
    OP_SW   = 3'd5,
    OP_BEQ  = 3'd6,
    OP_RSV  = 3'd7
  } exu_op_e;

  localparam int IMM_W = 16;
endpackage

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2:0]       op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic [IMM_W-1:0] imm,
  input  logic [DW-1:0]    pc,
  output logic [DW-1:0]    result,
  output logic             is_branch,
  output logic             taken,
  output logic [DW-1:0]    redirect
);
  localparam int EXT_W = DW - IMM_W;

  logic [DW-1:0]   imm_sx;
  logic [DW-1:0]   diff;
  logic [DW-1:0]   seq_pc;
  logic [2*DW-1:0] prod;
  exu_op_e         op_e;

  assign op_e   = exu_op_e'(op);
  assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign diff   = a - b;
  assign seq_pc = pc + DW'(4);
  assign prod   = a * b;

  always_comb begin
    is_branch = (op_e == OP_BEQ);
    taken     = is_branch && (diff == '0);
    redirect  = taken ? (seq_pc + (imm_sx << 2)) : seq_pc;
  end

  always_comb begin
    unique case (op_e)
      OP_ADD:         result = a + b;
      OP_SUB:         result = diff;
      OP_ADDI:        result = a + imm_sx;
      OP_MUL:         result = prod[DW-1:0];
      OP_LW, OP_SW:   result = a + imm_sx;
      OP_BEQ:         result = redirect;
      default:        result = '0;
    endcase
  end
endmodule

// File: rtl/exu_timer.sv
module exu_timer #(
  parameter int MUL_LAT = 4,
  parameter int ALU_LAT = 2,
  parameter int BUSY_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_mul,
  input  logic              handoff,
  output logic              running,
  output logic              done,
  output logic [BUSY_W-1:0] busy_cycles
);
  localparam int MAX_LAT = (MUL_LAT > ALU_LAT) ? MUL_LAT : ALU_LAT;
  localparam int CNT_W   = (MAX_LAT < 2) ? 1 : $clog2(MAX_LAT);
  localparam logic [CNT_W-1:0] MUL_LOAD = CNT_W'(MUL_LAT - 1);
  localparam logic [CNT_W-1:0] ALU_LOAD = CNT_W'(ALU_LAT - 1);

  logic [CNT_W-1:0] cnt;
  logic             counting;

  assign done     = running && (cnt == '0);
  assign counting = start || (running && (cnt != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= is_mul ? MUL_LOAD : ALU_LOAD;
    end else if (running) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      else if (handoff) running <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy_cycles <= '0;
    else if (counting) busy_cycles <= busy_cycles + 1'b1;
  end

  // R11
  busy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cycles != $past(busy_cycles)) |-> (busy_cycles == $past(busy_cycles) + 1'b1));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !handoff) |=> $stable(busy_cycles));

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !start);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_LAT - 1));
endmodule

// File: rtl/exu_outlatch.sv
module exu_outlatch #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [2:0]    d_op,
  input  logic [DW-1:0] d_result,
  input  logic [DW-1:0] d_pc,
  input  logic [DW-1:0] d_tag,
  input  logic          d_branch,
  input  logic          d_taken,
  input  logic [DW-1:0] d_redirect,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [2:0]    out_op,
  output logic [DW-1:0] out_result,
  output logic [DW-1:0] out_pc,
  output logic [DW-1:0] out_tag,
  output logic          br_done,
  output logic          br_taken,
  output logic [DW-1:0] br_target
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_op     <= '0;
      out_result <= '0;
      out_pc     <= '0;
      out_tag    <= '0;
    end else if (load) begin
      out_valid  <= 1'b1;
      out_op     <= d_op;
      out_result <= d_result;
      out_pc     <= d_pc;
      out_tag    <= d_tag;
    end else if (out_valid && out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_done   <= 1'b0;
      br_taken  <= 1'b0;
      br_target <= '0;
    end else begin
      br_done <= load && d_branch;
      if (load && d_branch) begin
        br_taken  <= d_taken;
        br_target <= d_redirect;
      end
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_pc)
                                   && $stable(out_tag) && $stable(out_op)));

  // R8
  load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid);
endmodule

// File: rtl/exu_stage.sv
module exu_stage
  import exu_pkg::*;
#(
  parameter int DW      = 32,
  parameter int MUL_LAT = 4,
  parameter int ALU_LAT = 2,
  parameter int BUSY_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [DW-1:0]     in_a,
  input  logic [DW-1:0]     in_b,
  input  logic [15:0]       in_imm,
  input  logic [DW-1:0]     in_pc,
  input  logic [DW-1:0]     in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_op,
  output logic [DW-1:0]     out_result,
  output logic [DW-1:0]     out_pc,
  output logic [DW-1:0]     out_tag,
  output logic              br_done,
  output logic              br_taken,
  output logic [DW-1:0]     br_target,
  output logic [BUSY_W-1:0] busy_cycles
);
  logic          running, done, start, handoff;
  logic [DW-1:0] alu_result, alu_redirect;
  logic          alu_branch, alu_taken;

  assign start    = in_valid && !running;
  assign handoff  = done && !out_valid;
  assign in_ready = handoff;

  exu_alu #(.DW(DW)) u_alu (
    .op       (in_op),
    .a        (in_a),
    .b        (in_b),
    .imm      (in_imm),
    .pc       (in_pc),
    .result   (alu_result),
    .is_branch(alu_branch),
    .taken    (alu_taken),
    .redirect (alu_redirect)
  );

  exu_timer #(.MUL_LAT(MUL_LAT), .ALU_LAT(ALU_LAT), .BUSY_W(BUSY_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .is_mul     (in_op == OP_MUL),
    .handoff    (handoff),
    .running    (running),
    .done       (done),
    .busy_cycles(busy_cycles)
  );

  exu_outlatch #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (handoff),
    .d_op      (in_op),
    .d_result  (alu_result),
    .d_pc      (in_pc),
    .d_tag     (in_tag),
    .d_branch  (alu_branch),
    .d_taken   (alu_taken),
    .d_redirect(alu_redirect),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_op    (out_op),
    .out_result(out_result),
    .out_pc    (out_pc),
    .out_tag   (out_tag),
    .br_done   (br_done),
    .br_taken  (br_taken),
    .br_target (br_target)
  );

  // R9
  ready_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> out_valid);

  // R7
  br_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_done |-> (out_valid && out_op == OP_BEQ && $rose(out_valid)));

  // R7
  br_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_done |=> !br_done);

  // R6
  br_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_done |-> (out_result == br_target));
endmodule

// File: tb/exu_stage_test.sv
module exu_stage_test;
  localparam int DW = 32;
  localparam int ML = 4;
  localparam int AL = 2;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_op = '0;
  logic [DW-1:0] in_a = '0, in_b = '0, in_pc = '0, in_tag = '0;
  logic [15:0]   in_imm = '0;
  logic          out_valid, out_ready = 1'b0;
  logic [2:0]    out_op;
  logic [DW-1:0] out_result, out_pc, out_tag, br_target;
  logic          br_done, br_taken;
  logic [31:0]   busy_cycles;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  exu_stage #(.DW(DW), .MUL_LAT(ML), .ALU_LAT(AL), .BUSY_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_imm(in_imm), .in_pc(in_pc),
    .in_tag(in_tag), .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_result(out_result), .out_pc(out_pc), .out_tag(out_tag),
    .br_done(br_done), .br_taken(br_taken), .br_target(br_target),
    .busy_cycles(busy_cycles)
  );

  localparam logic [2:0]  V_OP  [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd6, 3'd6, 3'd7};
  localparam logic [31:0] V_A   [NV] = '{32'd5, 32'd3, 32'd100, 32'h0001_0001, 32'h1000,
                                         32'h2000, 32'd9, 32'd9, 32'd7, 32'd55};
  localparam logic [31:0] V_B   [NV] = '{32'd7, 32'd10, 32'd0, 32'h0001_0001, 32'd0,
                                         32'd0, 32'd9, 32'd8, 32'd7, 32'd66};
  localparam logic [15:0] V_IMM [NV] = '{16'd0, 16'd0, 16'hFFFC, 16'd0, 16'h0010,
                                         16'hFFF8, 16'd3, 16'd3, 16'hFFFE, 16'd1};
  localparam logic [31:0] V_PC  [NV] = '{32'h10, 32'h14, 32'h18, 32'h1C, 32'h20,
                                         32'h24, 32'h40, 32'h40, 32'h100, 32'h2C};
  localparam logic [31:0] V_EXP [NV] = '{32'd12, 32'hFFFF_FFF9, 32'd96, 32'h0002_0001, 32'h1010,
                                         32'h1FF8, 32'h50, 32'h44, 32'hFC, 32'd0};
  localparam logic        V_TK  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic present(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic [31:0] pc, input logic [31:0] tag);
    in_op = op; in_a = a; in_b = b; in_imm = imm; in_pc = pc; in_tag = tag;
    in_valid = 1'b1;
  endtask

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cnt, ready_at, lat;
    bit hs;
    logic [31:0] b0;

    repeat (3) @(negedge clk);
    // R1 during reset
    check(!out_valid && !in_ready && !br_done && busy_cycles == 0, "R1", {out_valid, in_ready, br_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !in_ready && !br_done && busy_cycles == 0, "R1", busy_cycles, 0);

    // Table of vectors
    for (int i = 0; i < NV; i++) begin
      lat = (V_OP[i] == 3'd3) ? ML : AL;
      b0 = busy_cycles;
      present(V_OP[i], V_A[i], V_B[i], V_IMM[i], V_PC[i], 32'hA000_0000 + i);
      cnt = 0; ready_at = 0; hs = 0;
      while (!out_valid && cnt < 40) begin
        @(negedge clk);
        cnt++;
        if (hs) in_valid = 1'b0;
        hs = in_valid && in_ready;
        if (hs && ready_at == 0) ready_at = cnt;
      end
      // R2 / R3 timing, R9 ready position
      check(cnt == lat + 1, (V_OP[i] == 3'd3) ? "R3" : "R2", cnt, lat + 1);
      check(ready_at == lat, "R9", ready_at, lat);
      // R4 R5 R6 R3 results
      check(out_result == V_EXP[i], "R4/R5/R6 result", out_result, V_EXP[i]);
      // R12
      check(out_pc == V_PC[i] && out_tag == 32'hA000_0000 + i && out_op == V_OP[i], "R12", out_tag, 32'hA000_0000 + i);
      // R7
      check(br_done == (V_OP[i] == 3'd6), "R7", br_done, V_OP[i] == 3'd6);
      if (V_OP[i] == 3'd6) begin
        check(br_taken == V_TK[i] && br_target == V_EXP[i], "R6", br_target, V_EXP[i]);
      end
      // R11
      check(busy_cycles - b0 == lat, "R11", busy_cycles - b0, lat);
      @(negedge clk);
      check(!br_done, "R7 pulse width", br_done, 0);
      check(out_valid && out_result == V_EXP[i], "R10 hold", out_result, V_EXP[i]);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      check(!out_valid, "R10 clear", out_valid, 0);
    end

    // Back-pressure with a waiting multiply
    present(3'd0, 32'd1, 32'd2, 16'd0, 32'h200, 32'hB0);
    hs = 0;
    for (int k = 0; k < AL + 1; k++) begin
      @(negedge clk);
      if (hs) in_valid = 1'b0;
      hs = in_valid && in_ready;
    end
    check(out_valid && out_result == 32'd3, "R2", out_result, 3);
    b0 = busy_cycles;
    present(3'd3, 32'd6, 32'd7, 16'd0, 32'h204, 32'hB1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      // R9 no hand-off while latch full
      check(!in_ready, "R9 stall", in_ready, 0);
      check(out_valid && out_tag == 32'hB0 && out_result == 32'd3, "R10 hold", out_tag, 32'hB0);
    end
    // R11 exactly the multiply countdown
    check(busy_cycles - b0 == ML, "R11 wait", busy_cycles - b0, ML);
    out_ready = 1'b1;
    #1;
    // R8 drain and completion in the same cycle: no load now
    check(!in_ready, "R8", in_ready, 0);
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R8 next", {out_valid, in_ready}, 32'h1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_result == 32'd42 && out_tag == 32'hB1 && out_pc == 32'h204, "R3", out_result, 42);
    check(busy_cycles - b0 == ML, "R11", busy_cycles - b0, ML);
    @(negedge clk);
    check(!in_ready && busy_cycles - b0 == ML, "R11 idle", busy_cycles - b0, ML);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule